// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block takes characters from a small transmit queue and shifts them out on a single serial line, one bit per bit-rate tick. A separate baud divider supplies the tick. The host pushes bytes into the queue with a strobe. A set of line-format inputs selects the character format: 5 to 8 data bits, an optional parity bit (odd, even, or forced to a constant), and one or two stop bits. A break request drives the line low once the current character has finished.

The format is captured when each character is loaded. Changing the format inputs during a frame therefore does not affect that frame. Clearing either enable, or losing the clear-to-send gate, blocks only the start of the next character. A character already on the line always runs to its final stop bit. The busy flag covers both queued characters and the character on the line. The empty flag reports only the queue.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then the high stop bits. The line changes only on the clock edge that samples `bit_tick` high, so each bit lasts exactly one tick period. When idle, the line is high.
- R2: `len_code` selects the data-bit count: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Unused upper bits of the pushed byte are never sent.
- R3: With `par_on`=1 and `par_stick`=0, the parity bit makes the number of ones in the data plus parity even when `par_even`=1, and odd when `par_even`=0.
- R4: With `par_on`=1 and `par_stick`=1, the parity bit is constant: 1 when `par_even`=0 and 0 when `par_even`=1.
- R5: `stop_two`=1 sends two stop bits. `stop_two`=0 sends one.
- R6: While `brk_req`=1, the line is held low after the current character ends, and no new character starts. Clearing `brk_req` returns the line high.
- R7: A new character starts only when `xmit_on`=1 and `port_on`=1. Clearing either one mid-character lets that character complete, and then the line stays high.
- R8: `busy` goes high the cycle after a push makes the queue non-empty, whatever the enables are. It stays high until the tick that ends the last stop bit of the last character. `empty` is high exactly when the queue holds nothing.
- R9: After reset `ser_out`=1, `busy`=0 and `empty`=1.
- R10: With `cts_gate_on`=1, a new character starts only while `cts_in`=1. With `cts_gate_on`=0, `cts_in` is ignored.
- R11: A queued character whose start conditions hold begins on the tick that ends the previous frame's last stop bit, with no idle bit between frames. A push into a full queue (DEPTH entries) is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_data | input | 8 | Character to enqueue |
| push_valid | input | 1 | Enqueue strobe, one character per cycle |
| len_code | input | 2 | Data-bit count code |
| par_on | input | 1 | Parity bit enable |
| par_even | input | 1 | Even-parity select |
| par_stick | input | 1 | Constant-parity select |
| stop_two | input | 1 | Two stop bits select |
| brk_req | input | 1 | Break request |
| xmit_on | input | 1 | Transmitter enable |
| port_on | input | 1 | Whole-port enable |
| cts_gate_on | input | 1 | Clear-to-send gating enable |
| cts_in | input | 1 | Clear-to-send, high = asserted |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| ser_out | output | 1 | Serial line |
| busy | output | 1 | Queue or shifter occupied |
| empty | output | 1 | Queue empty |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse and that the control inputs are synchronous to `clk`. They make no assumption about the spacing between ticks. The stimulus drives every input on the falling edge and raises the tick for exactly one cycle, leaving an idle cycle between ticks. It changes the enables, the break request and the clear-to-send level only between ticks. The format inputs are changed only while the line is idle, because a format change mid-frame is outside what the frame checks model.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] push_data,
  input  logic       push_valid,
  input  logic [1:0] len_code,
  input  logic       par_on,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       stop_two,
  input  logic       brk_req,
  input  logic       xmit_on,
  input  logic       port_on,
  input  logic       cts_gate_on,
  input  logic       cts_in,
  input  logic       bit_tick,
  output logic       ser_out,
  output logic       busy,
  output logic       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t           st;
  logic [7:0]    q_mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bitc;
  logic [1:0]    f_len;
  logic          f_pe, f_two, f_par;

  logic [7:0] head, mask;
  logic       go, last_stop, load, do_push, odd_ones;

  assign head      = q_mem[rp];
  assign empty     = (cnt == '0);
  assign busy      = !empty || (st != S_IDLE);
  assign go        = !empty && xmit_on && port_on && (!cts_gate_on || cts_in) && !brk_req;
  assign last_stop = (st == S_STOP1 && !f_two) || (st == S_STOP2);
  assign load      = bit_tick && go && (st == S_IDLE || last_stop);
  assign do_push   = push_valid && (cnt != CW'(DEPTH));
  assign mask      = 8'hFF >> (2'd3 - len_code);
  assign odd_ones  = ^(head & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (load)    rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(load);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) q_mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sh    <= '0;
      bitc  <= '0;
      f_len <= '0;
      f_pe  <= 1'b0;
      f_two <= 1'b0;
      f_par <= 1'b0;
    end else if (load) begin
      st    <= S_START;
      sh    <= head;
      f_len <= len_code;
      f_pe  <= par_on;
      f_two <= stop_two;
      f_par <= par_stick ? !par_even : (odd_ones ^ !par_even);
    end else if (bit_tick) begin
      case (st)
        S_START: begin
          st   <= S_DATA;
          bitc <= '0;
        end
        S_DATA: begin
          sh <= sh >> 1;
          if (bitc == {1'b1, f_len}) st <= f_pe ? S_PAR : S_STOP1;
          else bitc <= bitc + 1'b1;
        end
        S_PAR:   st <= S_STOP1;
        S_STOP1: st <= f_two ? S_STOP2 : S_IDLE;
        S_STOP2: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_IDLE:  ser_out = !brk_req;
      S_START: ser_out = 1'b0;
      S_DATA:  ser_out = sh[0];
      S_PAR:   ser_out = f_par;
      default: ser_out = 1'b1;
    endcase
  end

  // R1
  tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> $past(bit_tick));

  // R7
  no_start_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !(xmit_on && port_on)) |=> (st == S_IDLE));

  // R10
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cts_gate_on && !cts_in) |=> (st == S_IDLE));

  // R6
  break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && brk_req) |=> (st == S_IDLE));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(push_valid));

  // R11
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !load) |=> (cnt == CW'(DEPTH)));
endmodule

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
  logic       clk = 0, rst_n = 0;
  logic [7:0] push_data = 0;
  logic       push_valid = 0;
  logic [1:0] len_code = 2'b11;
  logic       par_on = 0, par_even = 0, par_stick = 0, stop_two = 0, brk_req = 0;
  logic       xmit_on = 1, port_on = 1, cts_gate_on = 0, cts_in = 0, bit_tick = 0;
  logic       ser_out, busy, empty;
  int         total = 0, fails = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  uart_frame_tx #(.DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .push_data(push_data), .push_valid(push_valid),
    .len_code(len_code), .par_on(par_on), .par_even(par_even), .par_stick(par_stick),
    .stop_two(stop_two), .brk_req(brk_req), .xmit_on(xmit_on), .port_on(port_on),
    .cts_gate_on(cts_gate_on), .cts_in(cts_in), .bit_tick(bit_tick),
    .ser_out(ser_out), .busy(busy), .empty(empty));

  // {len_code, par_on, par_even, par_stick, stop_two, data}
  localparam logic [13:0] VEC [8] = '{
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C},
    {2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h1F},
    {2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h0A},
    {2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF},
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3}
  };

  function automatic int build(input logic [13:0] e, output logic [63:0] v);
    int n = 0, ones = 0, nb;
    v = '1;
    v[n] = 1'b0; n++;
    nb = 5 + int'(e[13:12]);
    for (int i = 0; i < nb; i++) begin
      v[n] = e[i]; ones += int'(e[i]); n++;
    end
    if (e[11]) begin
      if (e[9]) v[n] = !e[10];
      else      v[n] = e[10] ? (ones % 2 == 1) : (ones % 2 == 0);
      n++;
    end
    v[n] = 1'b1; n++;
    if (e[8]) begin v[n] = 1'b1; n++; end
    return n;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input int n);
    logic [63:0] m = (n >= 64) ? '1 : ((64'd1 << n) - 1);
    total++;
    if ((act & m) !== (exp & m)) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act & m, exp & m);
    end
  endtask

  task automatic push(input logic [7:0] d);
    push_data = d; push_valid = 1;
    @(negedge clk); push_valid = 0;
  endtask

  task automatic capture(input int n, output logic [63:0] v);
    v = '1;
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; @(negedge clk); bit_tick = 0;
      v[i] = ser_out;
      @(negedge clk);
    end
  endtask

  task automatic fmt(input logic [13:0] e);
    {len_code, par_on, par_even, par_stick, stop_two} = e[13:8];
  endtask

  localparam logic [13:0] F8N1 = 14'b11_0_0_0_0_00000000;

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, e1, e2;
    int n1, n2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset", {61'd0, ser_out, busy, empty}, {61'd0, 3'b101}, 3);

    for (int k = 0; k < 8; k++) begin
      fmt(VEC[k]);
      push(VEC[k][7:0]);
      n1 = build(VEC[k], e1);
      capture(n1, a);
      chk($sformatf("R1 R2 R3 R4 R5 frame %0d", k), a, e1, n1);
      chk("R8 busy during last stop", {63'd0, busy}, 64'd1, 1);
      capture(1, a);
      chk("R8 idle after frame", {62'd0, a[0], busy}, {62'd0, 2'b10}, 2);
    end

    fmt(F8N1);
    port_on = 0;
    push(8'h81);
    capture(3, a);
    chk("R7 disabled line idle", a, '1, 3);
    chk("R8 busy while disabled", {62'd0, busy, empty}, {62'd0, 2'b10}, 2);
    port_on = 1;
    n1 = build({F8N1[13:8], 8'h81}, e1);
    capture(n1 + 1, a);
    chk("R7 frame after enable", a, e1, n1 + 1);

    push(8'h33); push(8'h44);
    capture(1, a);
    xmit_on = 0;
    capture(13, b);
    n1 = build({F8N1[13:8], 8'h33}, e1);
    e2 = '1;
    for (int i = 0; i < 9; i++) e2[i] = e1[i + 1];
    chk("R7 graceful finish", b, e2, 13);
    chk("R7 queue held", {62'd0, busy, empty}, {62'd0, 2'b10}, 2);
    xmit_on = 1;
    n2 = build({F8N1[13:8], 8'h44}, e2);
    capture(n2 + 1, a);
    chk("R7 resumed frame", a, e2, n2 + 1);

    push(8'h12); push(8'h34);
    n1 = build({F8N1[13:8], 8'h12}, e1);
    n2 = build({F8N1[13:8], 8'h34}, e2);
    capture(21, a);
    chk("R11 back to back", a, (e1 & 64'h3FF) | ((e2 & 64'h3FF) << 10) | (64'd1 << 20), 21);

    port_on = 0;
    for (int i = 1; i <= 5; i++) push(8'(i));
    port_on = 1;
    capture(41, a);
    b = '0;
    for (int i = 0; i < 4; i++) begin
      n1 = build({F8N1[13:8], 8'(i + 1)}, e1);
      b |= (e1 & 64'h3FF) << (10 * i);
    end
    b |= 64'd1 << 40;
    chk("R11 full queue drops push", a, b, 41);
    chk("R11 queue drained", {62'd0, busy, empty}, {62'd0, 2'b01}, 2);

    cts_gate_on = 1; cts_in = 0;
    push(8'h55);
    capture(3, a);
    chk("R10 held by cts", a, '1, 3);
    cts_in = 1;
    n1 = build({F8N1[13:8], 8'h55}, e1);
    capture(n1 + 1, a);
    chk("R10 sent with cts", a, e1, n1 + 1);
    cts_gate_on = 0; cts_in = 0;
    push(8'h66);
    n1 = build({F8N1[13:8], 8'h66}, e1);
    capture(n1 + 1, a);
    chk("R10 cts ignored when gate off", a, e1, n1 + 1);

    push(8'h0F);
    capture(1, a);
    brk_req = 1;
    capture(12, b);
    n1 = build({F8N1[13:8], 8'h0F}, e1);
    e2 = '1;
    for (int i = 0; i < 9; i++) e2[i] = e1[i + 1];
    e2[9] = 0; e2[10] = 0; e2[11] = 0;
    chk("R6 break after char", b, e2, 12);
    brk_req = 0;
    capture(1, a);
    chk("R6 break released", a, '1, 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule